// File: doc/BRIEF.md
# Symmetric PWM timebase with buffered compares

This block drives two pulse-width modulated outputs from a single counter that climbs from zero to a programmable top value and then falls back to zero, giving centre-aligned waveforms whose period is twice the top value in clock cycles. Two compare values place the edges: channel A rises when the counter meets its compare on the way up and falls when it meets it on the way down. Channel B does the opposite, which gives a complementary-style pair.

The top value and both compare values are written into buffer registers through a small write port. They move into the working registers only when the counter sits at zero or at the top value, so a new setting never tears a half-period in progress. A phase register, written directly, can be loaded into the counter at any time by a single-cycle force-sync pulse. The counter, the outputs and the event strobes are visible at the ports, so the block can serve as the timing master for other logic.

Top module: `updown_pwm`

## Requirements
- R1: After reset the count is 0, counting_up is 1, both outputs are 0, and the top value, both compares and the phase are all 0.
- R2: While run is high with a top value P of 1 or more, the count steps by one through 0,1,...,P,P-1,...,1,0 and repeats every 2*P cycles. Each of the values 0 and P lasts exactly one cycle. counting_up is 1 on cycles whose count was reached by stepping up and 0 on cycles reached by stepping down.
- R3: zero_evt is high exactly on cycles where run is high and the count is 0. prd_evt is high exactly on cycles where run is high and the count equals the working top value.
- R4: wr_sel selects the buffer register: 0 is the top value, 1 is compare A, 2 is compare B. A write changes only the buffer. The working copy takes the buffer value at the clock edge that ends a cycle in which zero_evt or prd_evt is high.
- R5: pwm_a becomes 1 on the cycle after the count equals compare A while counting_up is 1. It becomes 0 on the cycle after such a match while counting_up is 0.
- R6: pwm_b becomes 0 on the cycle after the count equals compare B while counting_up is 1. It becomes 1 on the cycle after such a match while counting_up is 0.
- R7: A compare value of 0, or one greater than the working top value, never matches, and the output it controls keeps its level.
- R8: wr_sel value 3 writes the phase register, which takes effect at once. A force_sync pulse loads the count from the phase register on the next cycle and sets counting_up to 1, whether or not run is high.
- R9: While run is low and force_sync is low, the count, counting_up and both outputs hold their values, both strobes stay low, and no transfer to the working registers takes place. Writes still land in the buffers.
- R10: With a working top value of 0 and the count at 0, the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 top value, 1 compare A, 2 compare B, 3 phase |
| wr_data | input | CW | Write data |
| run | input | 1 | Counter enable |
| force_sync | input | 1 | Load the count from the phase register |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| zero_evt | output | 1 | Strobe: count at zero |
| prd_evt | output | 1 | Strobe: count at top value |
| counting_up | output | 1 | Current count direction |
| count | output | CW | Current count |

## Verification
The waveform is first driven with compares placed strictly inside the period and unequal to each other, so that a swapped rise and fall or a swapped channel shows at once. Compares are then rewritten in the middle of a half-period and the top value is shrunk and grown. These patterns separate a transfer made at both endpoints from one made at only one endpoint or made immediately. Compares of zero and above the top value, a compare equal to the top value, a top value of 1 and of 0, freezes with buffer writes, and force-sync pulses both while running and while frozen cover the boundary cases. A behavioural model steps alongside the design and compares every output on every cycle.

// File: rtl/updown_pwm.sv
module updown_pwm #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          run,
  input  logic          force_sync,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          zero_evt,
  output logic          prd_evt,
  output logic          counting_up,
  output logic [CW-1:0] count
);
  localparam logic [1:0] SEL_TOP = 2'd0;
  localparam logic [1:0] SEL_CA  = 2'd1;
  localparam logic [1:0] SEL_CB  = 2'd2;
  localparam logic [1:0] SEL_PH  = 2'd3;

  logic [CW-1:0] top_buf, ca_buf, cb_buf;
  logic [CW-1:0] top_q, ca_q, cb_q, phase_q;
  logic          hit_a, hit_b, endpoint;

  assign zero_evt = run && (count == '0);
  assign prd_evt  = run && (count == top_q);
  assign endpoint = zero_evt || prd_evt;
  assign hit_a    = (ca_q != '0) && (ca_q <= top_q) && (count == ca_q);
  assign hit_b    = (cb_q != '0) && (cb_q <= top_q) && (count == cb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      counting_up <= 1'b1;
    end else if (force_sync) begin
      count       <= phase_q;
      counting_up <= 1'b1;
    end else if (run) begin
      if (counting_up) begin
        if (count >= top_q) begin
          counting_up <= 1'b0;
          if (count != '0) count <= count - 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else if (count == '0) begin
        if (top_q != '0) begin
          counting_up <= 1'b1;
          count       <= {{(CW-1){1'b0}}, 1'b1};
        end
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_a <= 1'b0;
      pwm_b <= 1'b0;
    end else if (run) begin
      if (hit_a) pwm_a <= counting_up;
      if (hit_b) pwm_b <= !counting_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_buf <= '0;
      ca_buf  <= '0;
      cb_buf  <= '0;
      phase_q <= '0;
      top_q   <= '0;
      ca_q    <= '0;
      cb_q    <= '0;
    end else begin
      if (endpoint) begin
        top_q <= top_buf;
        ca_q  <= ca_buf;
        cb_q  <= cb_buf;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_TOP: top_buf <= wr_data;
          SEL_CA:  ca_buf  <= wr_data;
          SEL_CB:  cb_buf  <= wr_data;
          SEL_PH:  phase_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !force_sync) |=> ($stable(count) && $stable(pwm_a) && $stable(pwm_b) && $stable(counting_up)));

  // R8
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_sync |=> (count == $past(phase_q) && counting_up));

  // R2
  zero_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !force_sync && count == '0 && top_q != '0) |=> (count == {{(CW-1){1'b0}}, 1'b1}));

  // R5
  a_edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_a) |-> $past(run && count == ca_q));

  // R6
  b_edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_b) |-> $past(run && count == cb_q));

  // R4
  top_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(top_q) |-> $past(run && (count == '0 || count == top_q)));

  // R7
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_q == '0) |=> $stable(pwm_a));
endmodule

// File: tb/test_updown_pwm.sv
module test_updown_pwm;
  localparam int CW = 16;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, run = 1'b0, force_sync = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic pwm_a, pwm_b, zero_evt, prd_evt, counting_up;
  logic [CW-1:0] count;
  int errors = 0, checks = 0;
  string tag = "R1";
  bit done = 0;

  int m_cnt = 0, m_top = 0, m_ca = 0, m_cb = 0, m_tb = 0, m_cab = 0, m_cbb = 0, m_ph = 0;
  bit m_up = 1, m_a = 0, m_b = 0;

  always #4 clk = ~clk;

  updown_pwm #(.CW(CW)) i_updown_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(run), .force_sync(force_sync), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .zero_evt(zero_evt), .prd_evt(prd_evt), .counting_up(counting_up), .count(count));

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int nc;
    bit nu, na, nb, ev;
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_a = 0; m_b = 0;
      m_top = 0; m_ca = 0; m_cb = 0; m_tb = 0; m_cab = 0; m_cbb = 0; m_ph = 0;
    end else begin
      nc = m_cnt; nu = m_up; na = m_a; nb = m_b;
      ev = run && (m_cnt == 0 || m_cnt == m_top);
      if (run && m_ca != 0 && m_ca <= m_top && m_cnt == m_ca) na = m_up;
      if (run && m_cb != 0 && m_cb <= m_top && m_cnt == m_cb) nb = !m_up;
      if (force_sync) begin
        nc = m_ph; nu = 1;
      end else if (run) begin
        if (m_up) begin
          if (m_cnt >= m_top) begin nu = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else nc = m_cnt + 1;
        end else if (m_cnt == 0) begin
          if (m_top != 0) begin nu = 1; nc = 1; end
        end else nc = m_cnt - 1;
      end
      if (ev) begin m_top = m_tb; m_ca = m_cab; m_cb = m_cbb; end
      if (wr_en) begin
        if (wr_sel == 0) m_tb = int'(wr_data);
        else if (wr_sel == 1) m_cab = int'(wr_data);
        else if (wr_sel == 2) m_cbb = int'(wr_data);
        else m_ph = int'(wr_data);
      end
      m_cnt = nc; m_up = nu; m_a = na; m_b = nb;
    end
    #2;
    if (!done) begin
      chk({tag, " R2 count"}, int'(count), m_cnt);
      chk({tag, " R2 direction"}, int'(counting_up), int'(m_up));
      chk({tag, " R3 zero strobe"}, int'(zero_evt), int'(run && m_cnt == 0));
      chk({tag, " R3 top strobe"}, int'(prd_evt), int'(run && m_cnt == m_top));
      chk({tag, " R5 pwm_a"}, int'(pwm_a), int'(m_a));
      chk({tag, " R6 pwm_b"}, int'(pwm_b), int'(m_b));
    end
  end

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = CW'(val);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sync;
    @(negedge clk); force_sync = 1;
    @(negedge clk); force_sync = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int held;
    idle(3);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 direction", int'(counting_up), 1);
    chk("R1 pwm_a", int'(pwm_a), 0);
    chk("R1 pwm_b", int'(pwm_b), 0);
    rst_n = 1;
    idle(2);

    tag = "R4";
    wr(0, 10); wr(1, 4); wr(2, 6);
    @(negedge clk); run = 1;
    idle(63);
    wr(1, 8);
    idle(5);
    wr(0, 6);
    idle(40);
    wr(0, 12); wr(2, 12);
    idle(60);

    tag = "R7";
    wr(1, 0); wr(2, 20);
    idle(30);
    held = int'(pwm_a);
    idle(30);
    chk("R7 pwm_a holds with compare 0", int'(pwm_a), held);
    chk("R7 pwm_b holds with compare above top", int'(pwm_b), int'(m_b));

    tag = "R9";
    wr(1, 3); wr(2, 5);
    idle(17);
    @(negedge clk); run = 0;
    held = int'(count);
    wr(0, 5); wr(1, 2);
    idle(20);
    chk("R9 count frozen", int'(count), held);
    chk("R9 zero strobe low", int'(zero_evt), 0);
    @(negedge clk); run = 1;
    idle(40);

    tag = "R8";
    wr(3, 3);
    pulse_sync();
    chk("R8 count from phase while running", int'(count), 3);
    idle(20);
    @(negedge clk); run = 0;
    wr(3, 4);
    pulse_sync();
    chk("R8 count from phase while frozen", int'(count), 4);
    chk("R8 direction up after sync", int'(counting_up), 1);
    idle(3);
    @(negedge clk); run = 1;
    idle(30);

    tag = "R2";
    wr(0, 1); wr(1, 1); wr(2, 1);
    idle(20);

    tag = "R10";
    wr(0, 0);
    idle(20);
    chk("R10 count held at zero", int'(count), 0);
    chk("R10 zero strobe", int'(zero_evt), 1);
    wr(0, 3);
    idle(20);
    finish_run();
  end
endmodule